// File: doc/BRIEF.md
# Receiver Hold Reconfiguration Sequencer

This block is the operating-state controller of a radio receiver that lets software retune or rewrite settings quickly. After start-up and a first initialization, the receiver alternates between waiting for a frame sync and checking for end of message. Raising a hold control bit parks the receiver in a HOLD state. Software rewrites its settings there. Lowering the bit releases the receiver back into initialization. Hold is honoured only when the receiver runs as a slave. In self-polling operation the bit is ignored, and reconfiguration has to go through sleep instead.

A settling timer counts microsecond ticks from hold entry and from every configuration write made while holding. The block leaves HOLD only once the configured settling time has elapsed. When the PLL-recalibration enable is set, the release path runs a VCO calibration phase and then waits a channel-hop delay before init. Each phase uses a start strobe and a done handshake towards the PLL model. A per-band checker compares the magnitude of the requested frequency step against the largest step that may be taken without calibration. It raises a sticky flag when calibration is off and the step is too large.

States and transitions: STARTUP→INIT (start-up done), INIT→WAIT_SYNC (init done), WAIT_SYNC→EOM_CHECK (sync found), EOM_CHECK→WAIT_SYNC (message done), WAIT_SYNC/EOM_CHECK→HOLD (hold request in slave mode), HOLD→INIT (release, no calibration), HOLD→CAL (release, calibration), CAL→HOP (calibration done), HOP→INIT (hop delay elapsed).

Top module: `rxhold_seq`

## Requirements
- R1: A synchronous reset puts the machine in STARTUP with `cal_start` and `step_big` low. The state codes on `state_o` are STARTUP=0, INIT=1, WAIT_SYNC=2, EOM_CHECK=3, HOLD=4, CAL=5, HOP=6.
- R2: STARTUP moves to INIT on `startup_done`. INIT moves to WAIT_SYNC on `init_done`. WAIT_SYNC moves to EOM_CHECK on `sync_found`. EOM_CHECK moves to WAIT_SYNC on `eom_done`. Each move happens at the next clock edge.
- R3: With `self_poll` low, `hold_bit` high in WAIT_SYNC or EOM_CHECK enters HOLD at the next edge, taking priority over the other inputs. In STARTUP and INIT, `hold_bit` has no effect.
- R4: With `self_poll` high, `hold_bit` is ignored and the receive states behave as if it were low.
- R5: The machine stays in HOLD for as long as `hold_bit` is high.
- R6: The machine leaves HOLD at the first edge at which `hold_bit` is low and at least SETTLE_US `us_tick` pulses have been counted since the later of hold entry and the last `cfg_wr` seen in HOLD.
- R7: On release with `recal_en` low the next state is INIT. With `recal_en` high it is CAL, and `cal_start` is high for exactly the first cycle of CAL.
- R8: CAL waits for `cal_done` and then moves to HOP. HOP moves to INIT at the edge after HOP_US `us_tick` pulses have been counted since HOP entry.
- R9: In HOLD with `recal_en` low, `step_big` is set when the magnitude of the signed `step_khz` exceeds the band limit. The band codes are 0 for 315 MHz (1000 kHz), 1 for 434 MHz (1500 kHz), and 2 or 3 for 868/915 MHz (3000 kHz). With `recal_en` high the flag is not set.
- R10: `step_big` is cleared on the edge that enters HOLD and keeps its value in every other state.
- R11: A step equal to the limit does not set the flag. A negative step is judged by its magnitude, including the most negative code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| startup_done | input | 1 | Start-up sequencer finished |
| init_done | input | 1 | Demodulator initialization finished |
| sync_found | input | 1 | Frame sync detected |
| eom_done | input | 1 | End-of-message check finished |
| hold_bit | input | 1 | Hold control bit from the register file |
| recal_en | input | 1 | Run VCO calibration when leaving hold |
| self_poll | input | 1 | 1 = self-polling operation, 0 = slave run |
| cfg_wr | input | 1 | Configuration register written (restarts settling in HOLD) |
| band | input | 2 | Frequency band code |
| step_khz | input | STEP_W | Signed requested retune step in kHz |
| cal_done | input | 1 | VCO calibration finished |
| state_o | output | 3 | Current state code |
| cal_start | output | 1 | Calibration start strobe |
| step_big | output | 1 | Step too large for retune without calibration |

## Verification
The bench builds the block with SETTLE_US=6 and HOP_US=4 and keeps the default band limits. This makes the boundaries of the settling and hop windows land a few cycles after entry, so the cycles just before and just after each exit can be checked exactly, including a settling restart caused by a configuration write. With the limits at their defaults, the step checks test the true per-band thresholds, one kHz either side, and the most negative 16-bit step.

// File: rtl/rxhold_pkg.sv
package rxhold_pkg;

    typedef enum logic [2:0] {
        ST_STARTUP   = 3'd0,
        ST_INIT      = 3'd1,
        ST_WAIT_SYNC = 3'd2,
        ST_EOM_CHECK = 3'd3,
        ST_HOLD      = 3'd4,
        ST_CAL       = 3'd5,
        ST_HOP       = 3'd6
    } rx_state_t;

    localparam logic [1:0] BAND_315 = 2'd0;
    localparam logic [1:0] BAND_434 = 2'd1;
    localparam logic [1:0] BAND_868 = 2'd2;
    localparam logic [1:0] BAND_915 = 2'd3;

endpackage

// File: rtl/rxhold_us_timer.sv
// Saturating microsecond counter with synchronous clear.
module rxhold_us_timer #(
    parameter int MAX_COUNT = 40,
    localparam int CNT_W = $clog2(MAX_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(MAX_COUNT);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_o <= '0;
        end else if (tick && cnt_o != TOP_V) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // counter never passes its ceiling
    p_cnt_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= TOP_V);

endmodule

// File: rtl/rxhold_step_guard.sv
// Compares the magnitude of a signed step with the limit of the selected band.
module rxhold_step_guard
    import rxhold_pkg::*;
#(
    parameter int STEP_W     = 16,
    parameter int LIM_315KHZ = 1000,
    parameter int LIM_434KHZ = 1500,
    parameter int LIM_HIKHZ  = 3000,
    localparam int MAG_W = STEP_W + 1
) (
    input  logic [1:0]        band,
    input  logic [STEP_W-1:0] step_khz,
    output logic              over
);
    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] lim;

    always_comb begin
        ext = {step_khz[STEP_W-1], step_khz};
        mag = ext[MAG_W-1] ? (~ext + 1'b1) : ext;
        unique case (band)
            BAND_315: lim = MAG_W'(LIM_315KHZ);
            BAND_434: lim = MAG_W'(LIM_434KHZ);
            BAND_868,
            BAND_915: lim = MAG_W'(LIM_HIKHZ);
            default:  lim = MAG_W'(LIM_HIKHZ);
        endcase
        over = mag > lim;
    end

endmodule

// File: rtl/rxhold_seq.sv
module rxhold_seq
    import rxhold_pkg::*;
#(
    parameter int SETTLE_US  = 40,
    parameter int HOP_US     = 50,
    parameter int STEP_W     = 16,
    parameter int LIM_315KHZ = 1000,
    parameter int LIM_434KHZ = 1500,
    parameter int LIM_HIKHZ  = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              startup_done,
    input  logic              init_done,
    input  logic              sync_found,
    input  logic              eom_done,
    input  logic              hold_bit,
    input  logic              recal_en,
    input  logic              self_poll,
    input  logic              cfg_wr,
    input  logic [1:0]        band,
    input  logic [STEP_W-1:0] step_khz,
    input  logic              cal_done,
    output logic [2:0]        state_o,
    output logic              cal_start,
    output logic              step_big
);
    localparam int TMR_MAX = (SETTLE_US > HOP_US) ? SETTLE_US : HOP_US;
    localparam int CNT_W   = $clog2(TMR_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_V = CNT_W'(SETTLE_US);
    localparam logic [CNT_W-1:0] HOP_V    = CNT_W'(HOP_US);

    rx_state_t        state, nxt;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_clr;
    logic             step_over;
    logic             hold_req;
    logic             enter_hold;

    // hold honoured only from the receive states in slave run mode
    assign hold_req   = hold_bit && !self_poll &&
                        (state == ST_WAIT_SYNC || state == ST_EOM_CHECK);
    assign enter_hold = hold_req;

    rxhold_us_timer #(.MAX_COUNT(TMR_MAX)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .tick  (us_tick),
        .cnt_o (tmr_cnt)
    );

    rxhold_step_guard #(
        .STEP_W     (STEP_W),
        .LIM_315KHZ (LIM_315KHZ),
        .LIM_434KHZ (LIM_434KHZ),
        .LIM_HIKHZ  (LIM_HIKHZ)
    ) u_guard (
        .band     (band),
        .step_khz (step_khz),
        .over     (step_over)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_STARTUP:   if (startup_done) nxt = ST_INIT;
            ST_INIT:      if (init_done)    nxt = ST_WAIT_SYNC;
            ST_WAIT_SYNC: begin
                if (hold_req)        nxt = ST_HOLD;
                else if (sync_found) nxt = ST_EOM_CHECK;
            end
            ST_EOM_CHECK: begin
                if (hold_req)      nxt = ST_HOLD;
                else if (eom_done) nxt = ST_WAIT_SYNC;
            end
            ST_HOLD: begin
                if (!hold_bit && !cfg_wr && tmr_cnt >= SETTLE_V)
                    nxt = recal_en ? ST_CAL : ST_INIT;
            end
            ST_CAL:       if (cal_done) nxt = ST_HOP;
            ST_HOP:       if (tmr_cnt >= HOP_V) nxt = ST_INIT;
            default:      nxt = ST_STARTUP;
        endcase
    end

    // timer restarts on hold entry, on a configuration write in hold, and on hop entry
    assign tmr_clr = enter_hold ||
                     (state == ST_HOLD && cfg_wr) ||
                     (state != ST_HOP && nxt == ST_HOP);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_STARTUP;
        else     state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cal_start <= 1'b0;
            step_big  <= 1'b0;
        end else begin
            cal_start <= (state != ST_CAL) && (nxt == ST_CAL);
            if (enter_hold)
                step_big <= 1'b0;
            else if (state == ST_HOLD && !recal_en && step_over)
                step_big <= 1'b1;
        end
    end

    assign state_o = state;

    // ---------------- assertions ----------------
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (state_o == 3'd0 && !cal_start && !step_big));

    p_hold_entry_r3: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_WAIT_SYNC || state == ST_EOM_CHECK) && hold_bit && !self_poll)
        |=> state == ST_HOLD);

    p_no_hold_in_init_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT && !init_done) |=> state == ST_INIT);

    p_selfpoll_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_SYNC && self_poll && !sync_found) |=> state == ST_WAIT_SYNC);

    p_hold_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && hold_bit) |=> state == ST_HOLD);

    p_settle_window_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && tmr_cnt < SETTLE_V) |=> state == ST_HOLD);

    p_cal_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        cal_start |-> (state == ST_CAL && $past(state) != ST_CAL));

    p_cal_single_r7: assert property (@(posedge clk) disable iff (rst)
        cal_start |=> !cal_start);

    p_cal_wait_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAL && !cal_done) |=> state == ST_CAL);

    p_hop_window_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOP && tmr_cnt < HOP_V) |=> state == ST_HOP);

    p_flag_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_HOLD) |-> !step_big);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_HOLD && !enter_hold) |=> $stable(step_big));

    p_flag_no_recal_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && recal_en && !step_big) |=> !step_big);

endmodule

// File: tb/rxhold_seq_test.sv
module rxhold_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int STEP_W     = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              us_tick, startup_done, init_done, sync_found, eom_done;
    logic              hold_bit, recal_en, self_poll, cfg_wr, cal_done;
    logic [1:0]        band;
    logic [STEP_W-1:0] step_khz;
    logic [2:0]        state_o;
    logic              cal_start, step_big;

    int checks   = 0;
    int failures = 0;

    localparam logic [2:0] S_START = 3'd0, S_INIT = 3'd1, S_WAIT = 3'd2,
                           S_EOM = 3'd3, S_HOLD = 3'd4, S_CAL = 3'd5, S_HOP = 3'd6;

    // {band, step, recal, expected flag}
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 16'd1000, 1'b0, 1'b0},
        {2'd0, 16'd1001, 1'b0, 1'b1},
        {2'd0, 16'hFC17, 1'b0, 1'b1},   // -1001
        {2'd1, 16'd1500, 1'b0, 1'b0},
        {2'd1, 16'hFA23, 1'b0, 1'b1},   // -1501
        {2'd2, 16'd3000, 1'b0, 1'b0},
        {2'd2, 16'd3001, 1'b0, 1'b1},
        {2'd3, 16'hF447, 1'b0, 1'b1},   // -3001
        {2'd0, 16'd5000, 1'b1, 1'b0},
        {2'd1, 16'h8000, 1'b0, 1'b1}    // most negative code
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    rxhold_seq #(
        .SETTLE_US (6),
        .HOP_US    (4),
        .STEP_W    (STEP_W)
    ) uut (
        .clk, .rst, .us_tick, .startup_done, .init_done, .sync_found, .eom_done,
        .hold_bit, .recal_en, .self_poll, .cfg_wr, .band, .step_khz, .cal_done,
        .state_o, .cal_start, .step_big
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic back_to_wait();
        for (int k = 0; k < 30 && state_o != S_INIT; k++) cyc(1);
        init_done = 1'b1; cyc(1); init_done = 1'b0;
    endtask

    initial begin
        rst = 1'b1; us_tick = 1'b1; startup_done = 0; init_done = 0; sync_found = 0;
        eom_done = 0; hold_bit = 0; recal_en = 0; self_poll = 0; cfg_wr = 0;
        cal_done = 0; band = 2'd0; step_khz = '0;
        cyc(2);
        chk("R1 reset state", state_o, S_START);
        chk("R1 reset cal_start", cal_start, 0);
        chk("R1 reset step_big", step_big, 0);
        rst = 1'b0;

        // R3: hold ignored in STARTUP
        hold_bit = 1; cyc(2);
        chk("R3 hold in startup", state_o, S_START);
        startup_done = 1; cyc(1); startup_done = 0;
        chk("R2 startup->init", state_o, S_INIT);
        cyc(2);
        chk("R3 hold in init", state_o, S_INIT);
        hold_bit = 0; init_done = 1; cyc(1); init_done = 0;
        chk("R2 init->wait", state_o, S_WAIT);
        sync_found = 1; cyc(1); sync_found = 0;
        chk("R2 wait->eom", state_o, S_EOM);
        eom_done = 1; cyc(1); eom_done = 0;
        chk("R2 eom->wait", state_o, S_WAIT);

        // R4: self-polling ignores hold
        self_poll = 1; hold_bit = 1; cyc(3);
        chk("R4 self-poll wait", state_o, S_WAIT);
        sync_found = 1; cyc(1); sync_found = 0;
        chk("R4 self-poll eom", state_o, S_EOM);
        cyc(2);
        chk("R4 self-poll eom hold", state_o, S_EOM);
        self_poll = 0; cyc(1);
        chk("R3 hold from eom", state_o, S_HOLD);

        // R5: stays in hold while bit high
        cyc(10);
        chk("R5 hold kept", state_o, S_HOLD);
        hold_bit = 0; cyc(1);
        chk("R7 release no-cal -> init", state_o, S_INIT);
        init_done = 1; cyc(1); init_done = 0;

        // R6: settle window from entry
        hold_bit = 1; cyc(1);
        chk("R3 hold from wait", state_o, S_HOLD);
        hold_bit = 0; cyc(6);
        chk("R6 still hold at settle edge", state_o, S_HOLD);
        cyc(1);
        chk("R6 init after settle", state_o, S_INIT);
        init_done = 1; cyc(1); init_done = 0;

        // R6: cfg_wr restarts settling
        hold_bit = 1; cyc(1); cyc(3);
        hold_bit = 0; cfg_wr = 1; cyc(1); cfg_wr = 0;
        cyc(6);
        chk("R6 cfg_wr restart hold", state_o, S_HOLD);
        cyc(1);
        chk("R6 cfg_wr restart init", state_o, S_INIT);
        init_done = 1; cyc(1); init_done = 0;

        // R7/R8: calibration path
        recal_en = 1; hold_bit = 1; cyc(1);
        hold_bit = 0; cyc(7);
        chk("R7 cal state", state_o, S_CAL);
        chk("R7 cal_start pulse", cal_start, 1);
        cyc(1);
        chk("R7 cal_start single", cal_start, 0);
        chk("R8 cal waits", state_o, S_CAL);
        cal_done = 1; cyc(1); cal_done = 0;
        chk("R8 cal->hop", state_o, S_HOP);
        cyc(4);
        chk("R8 hop window", state_o, S_HOP);
        cyc(1);
        chk("R8 hop->init", state_o, S_INIT);
        recal_en = 0;
        init_done = 1; cyc(1); init_done = 0;

        // R9/R11: step limit table
        for (int i = 0; i < NV; i++) begin
            band = VEC[i][19:18]; step_khz = VEC[i][17:2]; recal_en = VEC[i][1];
            hold_bit = 1; cyc(2);
            chk($sformatf("R9 R11 step vector %0d", i), step_big, int'(VEC[i][0]));
            step_khz = '0; recal_en = 0; hold_bit = 0;
            back_to_wait();
        end

        // R10: sticky outside hold, cleared on entry
        chk("R10 flag sticky in wait", step_big, 1);
        sync_found = 1; cyc(1); sync_found = 0;
        chk("R10 flag sticky in eom", step_big, 1);
        hold_bit = 1; cyc(1);
        chk("R10 flag cleared on entry", step_big, 0);
        cyc(2);
        chk("R10 flag stays clear", step_big, 0);

        // R1: reset from hold
        rst = 1; cyc(1); rst = 0; hold_bit = 0;
        chk("R1 reset from hold", state_o, S_START);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule